// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches and jumps for a five-stage in-order pipeline. It takes the already-decoded control-flow kind, the two register operands, the incremented program counter (the address of the next sequential instruction) and the branch offset or jump index of the instruction in decode. From these it decides whether control flow changes and computes the new fetch address. When the flow changes, it drives a redirect to the fetch stage and flushes the wrongly fetched younger instructions, which become no-ops. The branch instruction itself continues down the pipeline.

A single parameter chooses the stage where the decision is made. With resolution in decode (stage 2), the new address is known in the same cycle the branch decodes, and one fetched instruction is discarded. With resolution in execute (stage 3), the branch is carried one register deeper. The redirect then comes one cycle later and discards two instructions: the one in IF/ID and the one entering ID/EX. The EX setting exists so that the two costs can be compared on the same pipeline.

A stall input from the hazard unit stops a branch in decode from resolving on operands that are not ready yet. The branch is resolved once the stall drops.

Top module: `decode_branch_resolver`

## Requirements
- R1: `brKind` codes are: 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 branch if rs ≤ 0, 4 branch if rs < 0, 5 branch if rs ≥ 0, 6 branch if rs > 0, 7 jump, 8 jump-and-link, 9 jump-register, 10 jump-register-and-link. Codes 11 to 15 act as none. Code 1 is taken when rsVal equals rtVal and code 2 when they differ. Both codes use the target nextPc + (sign-extended offset16 << 2); for example, nextPc 0x14 with offset 2 gives 0x1C.
- R2: Codes 3 to 6 compare rsVal, read as a signed two's-complement value, with zero. rtVal plays no part.
- R3: Codes 7 and 8 are always taken, with target {nextPc[31:28], jumpIndex, 2'b00}.
- R4: Codes 9 and 10 are always taken, with target rsVal.
- R5: When a code 8 or 10 resolves, linkWrite is 1 and linkAddr equals the nextPc of that instruction. For every other code, linkWrite is 0.
- R6: With RESOLVE_STAGE=2, a taken branch raises redirect and flushFetch in the same cycle it is presented in decode. flushDecode is never raised.
- R7: A not-taken branch, a none or unknown code, or decValid low gives redirect, flushFetch, flushDecode and linkWrite all 0.
- R8: With RESOLVE_STAGE=2, stall high holds redirect, flushFetch and linkWrite at 0.
- R9: With RESOLVE_STAGE=3, a taken branch raises redirect, flushFetch and flushDecode together, one cycle after it was presented in decode. The target is computed from the operands captured at that time.
- R10: With RESOLVE_STAGE=3, an instruction presented while stall is high is not captured, so no redirect follows it.
- R11: With RESOLVE_STAGE=3, the instruction in decode during a redirect cycle is discarded, so it causes no redirect in the next cycle.
- R12: While rstN is low, redirect, flushFetch, flushDecode and linkWrite are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decode stage holds a valid instruction |
| brKind | input | 4 | Control-flow kind code (R1) |
| stall | input | 1 | Hazard-unit stall for the decode stage |
| rsVal | input | 32 | First register operand |
| rtVal | input | 32 | Second register operand |
| nextPc | input | 32 | Address of the decoding instruction plus 4 |
| offset16 | input | 16 | Branch word offset |
| jumpIndex | input | 26 | Jump word index |
| redirect | output | 1 | Fetch must load redirectPc |
| redirectPc | output | 32 | New fetch address |
| flushFetch | output | 1 | Turn the IF/ID instruction into a no-op |
| flushDecode | output | 1 | Turn the instruction entering ID/EX into a no-op |
| linkWrite | output | 1 | Return address is to be written |
| linkAddr | output | 32 | Return address |

## Verification
The equal and not-equal branches are driven with matching and differing operand pairs, and with both forward and backward offsets, so that the sign extension of the offset is exercised. The sign-tested branches see a zero, a negative and a positive rs, which separates the less-than, less-or-equal, greater-or-equal and greater-than cases. Jumps use a nextPc with nonzero upper bits, to tell region concatenation apart from addition. The same stimulus drives a decode-resolving and an execute-resolving instance, which exposes the one-cycle difference in redirect timing, the extra flush, stall capture and the dropping of a shadowed branch.

// File: rtl/brres_pkg.sv
package brres_pkg;

  typedef enum logic [3:0] {
    KIND_NONE = 4'd0,
    KIND_BEQ  = 4'd1,
    KIND_BNE  = 4'd2,
    KIND_BLEZ = 4'd3,
    KIND_BLTZ = 4'd4,
    KIND_BGEZ = 4'd5,
    KIND_BGTZ = 4'd6,
    KIND_J    = 4'd7,
    KIND_JAL  = 4'd8,
    KIND_JR   = 4'd9,
    KIND_JALR = 4'd10
  } brKind_e;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgtSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    tgtSel_e tgtSel;
  } dpStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic opEq;
    logic aNeg;
    logic aZero;
  } cmpFlags_t;

endpackage

// File: rtl/brres_datapath.sv
module brres_datapath
  import brres_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int OFF_W      = 16,
  parameter int IDX_W      = 26,
  parameter bit EX_RESOLVE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [DATA_W-1:0] nextPc,
  input  logic [OFF_W-1:0]  offset16,
  input  logic [IDX_W-1:0]  jumpIndex,
  output cmpFlags_t         flags,
  output logic [DATA_W-1:0] targetPc,
  output logic [DATA_W-1:0] linkAddr
);

  localparam int SHIFT  = 2;
  localparam int SEXT_W = DATA_W - OFF_W - SHIFT;
  localparam int HI_W   = DATA_W - IDX_W - SHIFT;

  logic [DATA_W-1:0] rsUse, rtUse, pcUse;
  logic [OFF_W-1:0]  offUse;
  logic [IDX_W-1:0]  idxUse;

  generate
    if (EX_RESOLVE) begin : gExReg
      logic [DATA_W-1:0] rsQ, rtQ, pcQ;
      logic [OFF_W-1:0]  offQ;
      logic [IDX_W-1:0]  idxQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rsQ  <= '0;
          rtQ  <= '0;
          pcQ  <= '0;
          offQ <= '0;
          idxQ <= '0;
        end else if (strobe.capture) begin
          rsQ  <= rsVal;
          rtQ  <= rtVal;
          pcQ  <= nextPc;
          offQ <= offset16;
          idxQ <= jumpIndex;
        end
      end
      assign rsUse  = rsQ;
      assign rtUse  = rtQ;
      assign pcUse  = pcQ;
      assign offUse = offQ;
      assign idxUse = idxQ;
    end else begin : gIdPass
      assign rsUse  = rsVal;
      assign rtUse  = rtVal;
      assign pcUse  = nextPc;
      assign offUse = offset16;
      assign idxUse = jumpIndex;
    end
  endgenerate

  logic [DATA_W-1:0] relTarget, absTarget;

  always_comb begin
    relTarget = pcUse + {{SEXT_W{offUse[OFF_W-1]}}, offUse, {SHIFT{1'b0}}};
    absTarget = {pcUse[DATA_W-1 -: HI_W], idxUse, {SHIFT{1'b0}}};
    flags.opEq  = (rsUse == rtUse);
    flags.aNeg  = rsUse[DATA_W-1];
    flags.aZero = (rsUse == '0);
    unique case (strobe.tgtSel)
      TGT_ABS: targetPc = absTarget;
      TGT_REG: targetPc = rsUse;
      default: targetPc = relTarget;
    endcase
    linkAddr = pcUse;
  end

endmodule

// File: rtl/brres_control.sv
module brres_control
  import brres_pkg::*;
#(
  parameter int KIND_W     = 4,
  parameter bit EX_RESOLVE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [KIND_W-1:0] brKind,
  input  logic              stall,
  input  cmpFlags_t         flags,
  output dpStrobe_t         strobe,
  output logic              redirect,
  output logic              flushFetch,
  output logic              flushDecode,
  output logic              linkWrite
);

  logic    resolveValid;
  brKind_e resolveKind;
  brKind_e decKind;
  logic    taken;
  logic    captureNow;

  always_comb begin
    unique case (brKind)
      4'd1:    decKind = KIND_BEQ;
      4'd2:    decKind = KIND_BNE;
      4'd3:    decKind = KIND_BLEZ;
      4'd4:    decKind = KIND_BLTZ;
      4'd5:    decKind = KIND_BGEZ;
      4'd6:    decKind = KIND_BGTZ;
      4'd7:    decKind = KIND_J;
      4'd8:    decKind = KIND_JAL;
      4'd9:    decKind = KIND_JR;
      4'd10:   decKind = KIND_JALR;
      default: decKind = KIND_NONE;
    endcase
  end

  // a redirecting cycle discards whatever sits in decode
  assign captureNow = decValid & ~stall & ~redirect;

  generate
    if (EX_RESOLVE) begin : gExStage
      logic    exValid;
      brKind_e exKind;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          exValid <= 1'b0;
          exKind  <= KIND_NONE;
        end else begin
          exValid <= captureNow;
          exKind  <= captureNow ? decKind : KIND_NONE;
        end
      end
      assign resolveValid = exValid;
      assign resolveKind  = exKind;
    end else begin : gIdStage
      assign resolveValid = decValid & ~stall & rstN;
      assign resolveKind  = decKind;
    end
  endgenerate

  always_comb begin
    taken         = 1'b0;
    strobe.tgtSel = TGT_REL;
    unique case (resolveKind)
      KIND_BEQ:  taken = flags.opEq;
      KIND_BNE:  taken = ~flags.opEq;
      KIND_BLEZ: taken = flags.aNeg | flags.aZero;
      KIND_BLTZ: taken = flags.aNeg;
      KIND_BGEZ: taken = ~flags.aNeg;
      KIND_BGTZ: taken = ~flags.aNeg & ~flags.aZero;
      KIND_J, KIND_JAL: begin
        taken         = 1'b1;
        strobe.tgtSel = TGT_ABS;
      end
      KIND_JR, KIND_JALR: begin
        taken         = 1'b1;
        strobe.tgtSel = TGT_REG;
      end
      default: taken = 1'b0;
    endcase
    strobe.capture = captureNow;
    redirect       = resolveValid & taken;
    flushFetch     = redirect;
    flushDecode    = EX_RESOLVE ? redirect : 1'b0;
    linkWrite      = resolveValid &
                     ((resolveKind == KIND_JAL) | (resolveKind == KIND_JALR));
  end

endmodule

// File: rtl/decode_branch_resolver.sv
module decode_branch_resolver
  import brres_pkg::*;
#(
  parameter int RESOLVE_STAGE = 2,
  parameter int DATA_W        = 32,
  parameter int OFF_W         = 16,
  parameter int IDX_W         = 26,
  parameter int KIND_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [KIND_W-1:0] brKind,
  input  logic              stall,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [DATA_W-1:0] nextPc,
  input  logic [OFF_W-1:0]  offset16,
  input  logic [IDX_W-1:0]  jumpIndex,
  output logic              redirect,
  output logic [DATA_W-1:0] redirectPc,
  output logic              flushFetch,
  output logic              flushDecode,
  output logic              linkWrite,
  output logic [DATA_W-1:0] linkAddr
);

  localparam bit EX_RESOLVE = (RESOLVE_STAGE >= 3);

  dpStrobe_t strobe;
  cmpFlags_t flags;

  brres_control #(
    .KIND_W    (KIND_W),
    .EX_RESOLVE(EX_RESOLVE)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .decValid   (decValid),
    .brKind     (brKind),
    .stall      (stall),
    .flags      (flags),
    .strobe     (strobe),
    .redirect   (redirect),
    .flushFetch (flushFetch),
    .flushDecode(flushDecode),
    .linkWrite  (linkWrite)
  );

  brres_datapath #(
    .DATA_W    (DATA_W),
    .OFF_W     (OFF_W),
    .IDX_W     (IDX_W),
    .EX_RESOLVE(EX_RESOLVE)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rsVal    (rsVal),
    .rtVal    (rtVal),
    .nextPc   (nextPc),
    .offset16 (offset16),
    .jumpIndex(jumpIndex),
    .flags    (flags),
    .targetPc (redirectPc),
    .linkAddr (linkAddr)
  );

endmodule

// File: rtl/brres_checker.sv
module brres_checker #(
  parameter int RESOLVE_STAGE = 2
) (
  input logic clk,
  input logic rstN,
  input logic stall,
  input logic redirect,
  input logic flushFetch,
  input logic flushDecode,
  input logic linkWrite
);

  AST_REDIRECT_FLUSHES: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> flushFetch); // R6

  AST_LINK_ON_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    linkWrite |-> redirect); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> !redirect && !flushFetch && !flushDecode && !linkWrite); // R12

  generate
    if (RESOLVE_STAGE >= 3) begin : gEx
      AST_EX_TWO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
        redirect |-> flushDecode); // R9

      AST_EX_SHADOW_DROP: assert property (@(posedge clk) disable iff (!rstN)
        redirect |=> !redirect); // R11
    end else begin : gId
      AST_ID_SINGLE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
        flushFetch |-> !flushDecode); // R6

      AST_ID_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        stall |-> !redirect && !flushFetch && !linkWrite); // R8
    end
  endgenerate

endmodule

bind decode_branch_resolver brres_checker #(.RESOLVE_STAGE(RESOLVE_STAGE)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .stall      (stall),
  .redirect   (redirect),
  .flushFetch (flushFetch),
  .flushDecode(flushDecode),
  .linkWrite  (linkWrite)
);

// File: tb/tb_decode_branch_resolver.sv
module tb_decode_branch_resolver;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        decValid = 1'b0;
  logic [3:0]  brKind = 4'd0;
  logic        stall = 1'b0;
  logic [31:0] rsVal = '0, rtVal = '0, nextPc = '0;
  logic [15:0] offset16 = '0;
  logic [25:0] jumpIndex = '0;

  logic        idRedir, idFf, idFd, idLw;
  logic [31:0] idPc, idLa;
  logic        exRedir, exFf, exFd, exLw;
  logic [31:0] exPc, exLa;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decode_branch_resolver #(.RESOLVE_STAGE(2)) dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .brKind(brKind), .stall(stall),
    .rsVal(rsVal), .rtVal(rtVal), .nextPc(nextPc), .offset16(offset16),
    .jumpIndex(jumpIndex), .redirect(idRedir), .redirectPc(idPc),
    .flushFetch(idFf), .flushDecode(idFd), .linkWrite(idLw), .linkAddr(idLa));

  decode_branch_resolver #(.RESOLVE_STAGE(3)) dutEx (
    .clk(clk), .rstN(rstN), .decValid(decValid), .brKind(brKind), .stall(stall),
    .rsVal(rsVal), .rtVal(rtVal), .nextPc(nextPc), .offset16(offset16),
    .jumpIndex(jumpIndex), .redirect(exRedir), .redirectPc(exPc),
    .flushFetch(exFf), .flushDecode(exFd), .linkWrite(exLw), .linkAddr(exLa));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive at the falling edge, leave time for combinational settling
  task automatic present(logic [3:0] k, logic [31:0] rs, logic [31:0] rt,
                         logic [31:0] pc4, logic [15:0] off, logic [25:0] idx,
                         logic st, logic v);
    @(negedge clk);
    brKind = k; rsVal = rs; rtVal = rt; nextPc = pc4;
    offset16 = off; jumpIndex = idx; stall = st; decValid = v;
    #2;
  endtask

  task automatic idle();
    present(4'd0, '0, '0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic expectId(string req, logic r, logic [31:0] pc, logic lw);
    check({req, " redirect"}, 32'(idRedir), 32'(r));
    check({req, " flushFetch"}, 32'(idFf), 32'(r));
    check({req, " flushDecode"}, 32'(idFd), 32'd0);
    check({req, " linkWrite"}, 32'(idLw), 32'(lw));
    if (r) check({req, " target"}, idPc, pc);
  endtask

  task automatic tReset();
    @(negedge clk);
    brKind = 4'd7; decValid = 1'b1; jumpIndex = 26'h1;
    #2;
    check("R12 id redirect in reset", 32'(idRedir), 32'd0);
    check("R12 id flushFetch in reset", 32'(idFf), 32'd0);
    check("R12 ex redirect in reset", 32'(exRedir), 32'd0);
    check("R12 ex flushDecode in reset", 32'(exFd), 32'd0);
    @(negedge clk);
    decValid = 1'b0;
    rstN = 1'b1;
  endtask

  task automatic tEqualBranches();
    present(4'd1, 32'd5, 32'd5, 32'h14, 16'd2, '0, 1'b0, 1'b1);
    expectId("R1 beq equal fwd", 1'b1, 32'h1C, 1'b0);
    present(4'd1, 32'd5, 32'd6, 32'h14, 16'd2, '0, 1'b0, 1'b1);
    expectId("R7 beq differ", 1'b0, 32'h0, 1'b0);
    present(4'd2, 32'd5, 32'd6, 32'h100, 16'hFFFE, '0, 1'b0, 1'b1);
    expectId("R1 bne differ back", 1'b1, 32'hF8, 1'b0);
    present(4'd2, 32'hDEAD, 32'hDEAD, 32'h100, 16'h4, '0, 1'b0, 1'b1);
    expectId("R7 bne equal", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic tSignBranches();
    present(4'd3, 32'd0, 32'd9, 32'h40, 16'd1, '0, 1'b0, 1'b1);
    expectId("R2 blez zero", 1'b1, 32'h44, 1'b0);
    present(4'd4, 32'd0, 32'hFFFF_FFFF, 32'h40, 16'd1, '0, 1'b0, 1'b1);
    expectId("R2 bltz zero", 1'b0, 32'h0, 1'b0);
    present(4'd5, 32'd0, 32'hFFFF_FFFF, 32'h40, 16'd1, '0, 1'b0, 1'b1);
    expectId("R2 bgez zero", 1'b1, 32'h44, 1'b0);
    present(4'd6, 32'd0, 32'd1, 32'h40, 16'd1, '0, 1'b0, 1'b1);
    expectId("R2 bgtz zero", 1'b0, 32'h0, 1'b0);
    present(4'd4, 32'hFFFF_FFFF, 32'd0, 32'h40, 16'd3, '0, 1'b0, 1'b1);
    expectId("R2 bltz neg", 1'b1, 32'h4C, 1'b0);
    present(4'd6, 32'hFFFF_FFFF, 32'd0, 32'h40, 16'd3, '0, 1'b0, 1'b1);
    expectId("R2 bgtz neg", 1'b0, 32'h0, 1'b0);
    present(4'd6, 32'd7, 32'd0, 32'h40, 16'd3, '0, 1'b0, 1'b1);
    expectId("R2 bgtz pos", 1'b1, 32'h4C, 1'b0);
    present(4'd3, 32'd7, 32'd0, 32'h40, 16'd3, '0, 1'b0, 1'b1);
    expectId("R2 blez pos", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic tJumps();
    present(4'd7, 32'd1, 32'd2, 32'hA000_0010, 16'h0, 26'h123456, 1'b0, 1'b1);
    expectId("R3 j region", 1'b1, 32'hA048_D158, 1'b0);
    present(4'd8, 32'd1, 32'd2, 32'hA000_0010, 16'h0, 26'h123456, 1'b0, 1'b1);
    expectId("R3 jal region", 1'b1, 32'hA048_D158, 1'b1);
    check("R5 jal link addr", idLa, 32'hA000_0010);
    present(4'd9, 32'h0040_0200, 32'd0, 32'h8000, 16'h0, 26'h0, 1'b0, 1'b1);
    expectId("R4 jr reg", 1'b1, 32'h0040_0200, 1'b0);
    present(4'd10, 32'h0040_0300, 32'd0, 32'h8004, 16'h0, 26'h0, 1'b0, 1'b1);
    expectId("R4 jalr reg", 1'b1, 32'h0040_0300, 1'b1);
    check("R5 jalr link addr", idLa, 32'h8004);
  endtask

  task automatic tQuiet();
    present(4'd0, 32'd1, 32'd1, 32'h20, 16'd1, 26'h1, 1'b0, 1'b1);
    expectId("R7 kind none", 1'b0, 32'h0, 1'b0);
    present(4'd12, 32'd1, 32'd1, 32'h20, 16'd1, 26'h1, 1'b0, 1'b1);
    expectId("R7 kind unknown", 1'b0, 32'h0, 1'b0);
    present(4'd7, 32'd1, 32'd1, 32'h20, 16'd1, 26'h1, 1'b0, 1'b0);
    expectId("R7 valid low", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic tStall();
    present(4'd1, 32'd3, 32'd3, 32'h14, 16'd2, '0, 1'b1, 1'b1);
    expectId("R8 stalled beq", 1'b0, 32'h0, 1'b0);
    present(4'd8, 32'd3, 32'd3, 32'h14, 16'd2, 26'h5, 1'b1, 1'b1);
    expectId("R8 stalled jal", 1'b0, 32'h0, 1'b0);
    present(4'd8, 32'd3, 32'd3, 32'h14, 16'd2, 26'h5, 1'b0, 1'b1);
    expectId("R8 released jal", 1'b1, 32'h0000_0014, 1'b1);
  endtask

  task automatic tExTiming();
    idle();
    present(4'd1, 32'd5, 32'd5, 32'h14, 16'd2, '0, 1'b0, 1'b1);
    check("R9 ex not yet", 32'(exRedir), 32'd0);
    idle();
    check("R9 ex redirect", 32'(exRedir), 32'd1);
    check("R9 ex flushFetch", 32'(exFf), 32'd1);
    check("R9 ex flushDecode", 32'(exFd), 32'd1);
    check("R9 ex target", exPc, 32'h1C);
    idle();
    check("R9 ex one cycle only", 32'(exRedir), 32'd0);
  endtask

  task automatic tExStall();
    idle();
    present(4'd9, 32'h400, 32'd0, 32'h14, 16'd0, '0, 1'b1, 1'b1);
    idle();
    check("R10 ex stalled not captured", 32'(exRedir), 32'd0);
    check("R10 ex stalled no flush", 32'(exFd), 32'd0);
  endtask

  task automatic tExShadow();
    idle();
    present(4'd7, 32'd0, 32'd0, 32'h14, 16'd0, 26'h40, 1'b0, 1'b1);
    present(4'd9, 32'h600, 32'd0, 32'h18, 16'd0, 26'h0, 1'b0, 1'b1);
    check("R11 ex first redirect", 32'(exRedir), 32'd1);
    check("R3 ex jump target", exPc, 32'h100);
    idle();
    check("R11 ex shadow dropped", 32'(exRedir), 32'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    tReset();
    tEqualBranches();
    tSignBranches();
    tJumps();
    tQuiet();
    tStall();
    tExTiming();
    tExStall();
    tExShadow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule